// File: doc/BRIEF.md
# Greedy Clamp-Search Controller

This block searches for a maximal set of cells in a reconfigurable region that can be tied to constant values without hurting a measured fitness score. After a start pulse it first asks an external evaluator for a reference score with nothing tied off. It then works through the cells in index order. For each cell it ties the cell to a pseudo-random constant and asks for the score again. The evaluator reads the tie-off pattern from the block's outputs during each request. If the new score falls further below the reference than a programmed margin allows, the tie-off is withdrawn. Otherwise it is kept.

Cells that are already tied are not tried again. The block keeps making passes over the region as long as the previous pass kept at least one new tie-off. It stops after a pass that kept none, and it signals the end with a one-cycle pulse. The outputs are a tie-enable vector and a tie-value vector, with one bit per cell. Only one score request is in flight at any time.

Top module: `prune_ctrl`

## Requirements
- R1: After reset, clamp_mask and clamp_val are all zero, and eval_req, busy and done are low.
- R2: A start pulse while idle clears clamp_mask and clamp_val, latches tolerance, and raises eval_req for a reference measurement with clamp_mask all zero. The score returned with the acknowledge becomes the baseline for the whole run.
- R3: eval_req stays high until eval_ack is sampled high at a clock edge. While the request waits, clamp_mask and clamp_val do not change. eval_req is low for at least one cycle between two requests.
- R4: Trials visit cells in ascending index from 0 within each pass, and skip cells whose clamp_mask bit is already set. Each trial sets exactly one new clamp_mask bit before its request.
- R5: The constant for a trial is bit 0 of a 16-bit right-shifting Galois LFSR. When bit 0 is 1, the next state is the state shifted right by one and XORed with 0xB400; when bit 0 is 0, it is only the shift. The LFSR starts from 0xACE1 at reset, keeps its state across runs, and advances exactly once per trial. It never advances for the reference measurement.
- R6: A trial fails when score + tolerance < baseline, computed unsigned without wrap. A failed trial clears both the cell's clamp_mask bit and its clamp_val bit. Any other result keeps the clamp.
- R7: A score that is exactly baseline minus tolerance keeps the clamp.
- R8: After the last cell, a new pass starts at index 0 if the pass kept any clamp. Otherwise the search ends.
- R9: busy is high from the accepted start until the search ends. done pulses for exactly one cycle as busy falls. A start seen while busy is ignored.
- R10: A clamp_val bit is never 1 while its clamp_mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| tolerance | input | SCORE_W | Allowed score drop below baseline |
| eval_req | output | 1 | Score measurement request |
| eval_ack | input | 1 | Evaluator completion strobe |
| eval_score | input | SCORE_W | Score valid with eval_ack |
| clamp_mask | output | NUM_CELLS | Tie-enable per cell |
| clamp_val | output | NUM_CELLS | Tie constant per cell |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |

## Verification
The bench evaluator scores each tie-off pattern from a per-cell, per-value cost table. Several cost profiles are used, and each one separates different behaviour. With all costs zero, every cell is kept in the first pass, which confirms the request count and the confirming final pass. With all costs prohibitive, nothing is kept, which shows that withdrawal clears both vectors. A profile where only the constant 1 is costly forces repeated passes, in which reverted cells are retried with fresh LFSR bits until every cell ends at 0. A cost exactly equal to the tolerance probes the boundary of the comparison. Random cost tables at two tolerances, combined with random acknowledge latency, compare every request pattern against an independent reference model.

// File: rtl/prune_pkg.sv
// Package: shared state encoding for the clamp-search controller.
// Assumes: nothing beyond IEEE 1800-2017.
package prune_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BASE  = 2'd1,
        ST_PICK  = 2'd2,
        ST_TRIAL = 2'd3
    } prune_state_e;
endpackage

// File: rtl/prune_lfsr.sv
// Module: right-shifting Galois LFSR that supplies one pseudo-random bit per step.
// Assumes: SEED is nonzero; the state is kept across searches and reset only by rst_n.
module prune_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic rnd_bit
);
    logic [WIDTH-1:0] state_q;

    // Purpose: advance the generator once per requested step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED[WIDTH-1:0];
        else if (step)
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS[WIDTH-1:0] : '0);
    end

    assign rnd_bit = state_q[0];

    assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/prune_judge.sv
// Module: decides whether a trial score counts as a degradation.
// Assumes: scores and the tolerance are unsigned; the sum is widened so it cannot wrap.
module prune_judge #(
    parameter int SCORE_W = 16
) (
    input  logic [SCORE_W-1:0] score,
    input  logic [SCORE_W-1:0] baseline,
    input  logic [SCORE_W-1:0] tol,
    output logic               degraded
);
    logic [SCORE_W:0] lifted;

    // Purpose: compare score plus margin against the baseline at full width.
    always_comb begin
        lifted   = {1'b0, score} + {1'b0, tol};
        degraded = lifted < {1'b0, baseline};
    end
endmodule

// File: rtl/prune_ctrl.sv
// Module: greedy trial-and-revert search for the largest set of tie-offs that
// keep fitness. It measures a baseline, tries each untied cell with an LFSR
// constant, withdraws the tie-off when the score drops beyond the tolerance,
// and repeats passes until a pass keeps nothing new.
// Assumes: the evaluator reads clamp_mask/clamp_val while eval_req is high and
// returns a one-cycle eval_ack with eval_score.
module prune_ctrl #(
    parameter int          NUM_CELLS = 100,
    parameter int          SCORE_W   = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SCORE_W-1:0]   tolerance,
    output logic                 eval_req,
    input  logic                 eval_ack,
    input  logic [SCORE_W-1:0]   eval_score,
    output logic [NUM_CELLS-1:0] clamp_mask,
    output logic [NUM_CELLS-1:0] clamp_val,
    output logic                 busy,
    output logic                 done
);
    import prune_pkg::*;

    localparam int IDX_W = $clog2(NUM_CELLS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CELLS);

    prune_state_e         state_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 changed_q;
    logic                 done_q;
    logic [SCORE_W-1:0]   base_q;
    logic [SCORE_W-1:0]   tol_q;
    logic [NUM_CELLS-1:0] mask_q;
    logic [NUM_CELLS-1:0] val_q;

    logic pass_end;
    logic cur_clamped;
    logic lfsr_step;
    logic rnd_bit;
    logic degraded;

    // Purpose: flag the end of a pass and the tie state of the current cell.
    always_comb begin
        pass_end    = (idx_q == LAST_IDX);
        cur_clamped = pass_end ? 1'b1 : mask_q[idx_q];
        lfsr_step   = (state_q == ST_PICK) && !cur_clamped;
    end

    prune_lfsr #(
        .WIDTH (16),
        .TAPS  (16'hB400),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (lfsr_step),
        .rnd_bit (rnd_bit)
    );

    prune_judge #(
        .SCORE_W (SCORE_W)
    ) u_judge (
        .score    (eval_score),
        .baseline (base_q),
        .tol      (tol_q),
        .degraded (degraded)
    );

    // Purpose: sequence baseline, trials, pass restarts and the end of the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            changed_q <= 1'b0;
            done_q    <= 1'b0;
            base_q    <= '0;
            tol_q     <= '0;
            mask_q    <= '0;
            val_q     <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= '0;
                        val_q   <= '0;
                        tol_q   <= tolerance;
                        state_q <= ST_BASE;
                    end
                end
                ST_BASE: begin
                    if (eval_ack) begin
                        base_q    <= eval_score;
                        idx_q     <= '0;
                        changed_q <= 1'b0;
                        state_q   <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (pass_end) begin
                        if (changed_q) begin
                            idx_q     <= '0;
                            changed_q <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else if (cur_clamped) begin
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        mask_q[idx_q] <= 1'b1;
                        val_q[idx_q]  <= rnd_bit;
                        state_q       <= ST_TRIAL;
                    end
                end
                ST_TRIAL: begin
                    if (eval_ack) begin
                        if (degraded) begin
                            mask_q[idx_q] <= 1'b0;
                            val_q[idx_q]  <= 1'b0;
                        end else begin
                            changed_q <= 1'b1;
                        end
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_PICK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign eval_req   = (state_q == ST_BASE) || (state_q == ST_TRIAL);
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign clamp_mask = mask_q;
    assign clamp_val  = val_q;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && !eval_ack) |=> eval_req);
    assert_pattern_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_req && !eval_ack) |=> ($stable(clamp_mask) && $stable(clamp_val)));
    assert_one_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_IDLE) |-> ($countones(clamp_mask ^ $past(clamp_mask)) <= 1));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !eval_req));
    assert_val_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_val & ~clamp_mask) == '0);
endmodule

// File: tb/sim_prune_ctrl.sv
module sim_prune_ctrl;
    localparam int N  = 100;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] tolerance = '0;
    logic          eval_req;
    logic          eval_ack = 1'b0;
    logic [SW-1:0] eval_score = '0;
    logic [N-1:0]  clamp_mask;
    logic [N-1:0]  clamp_val;
    logic          busy;
    logic          done;

    always #2.5 clk = ~clk;

    prune_ctrl #(.NUM_CELLS(N), .SCORE_W(SW), .LFSR_SEED(16'hACE1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tolerance(tolerance),
        .eval_req(eval_req), .eval_ack(eval_ack), .eval_score(eval_score),
        .clamp_mask(clamp_mask), .clamp_val(clamp_val), .busy(busy), .done(done)
    );

    int checks = 0;
    int failures = 0;

    // cost tables and reference model state
    int           cost0 [N];
    int           cost1 [N];
    int           base_level = 1000;
    int           m_phase;
    int           m_idx;
    bit           m_changed;
    bit           m_fin;
    logic [N-1:0] m_mask;
    logic [N-1:0] m_val;
    logic [15:0]  m_lfsr = 16'hACE1;
    int           m_base;
    int           m_tol;
    int           req_count;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int score_of(input logic [N-1:0] mk, input logic [N-1:0] vl);
        int s = base_level;
        for (int c = 0; c < N; c++)
            if (mk[c]) s -= (vl[c] ? cost1[c] : cost0[c]);
        if (s < 0) s = 0;
        return s;
    endfunction

    // model: find the next trial or conclude the search (R4, R5, R8)
    task automatic model_next();
        forever begin
            while (m_idx < N && m_mask[m_idx]) m_idx++;
            if (m_idx < N) begin
                m_mask[m_idx] = 1'b1;
                m_val[m_idx]  = m_lfsr[0];
                m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
                return;
            end
            if (m_changed) begin
                m_idx = 0;
                m_changed = 1'b0;
            end else begin
                m_fin = 1'b1;
                return;
            end
        end
    endtask

    // evaluator: checks each request against the model and answers it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && eval_req) begin
                int sc;
                int dly;
                req_count++;
                chk(!m_fin, "R8 request after expected end", 128'(req_count), 128'(0));
                chk(clamp_mask == m_mask, "R4 request mask", 128'(clamp_mask), 128'(m_mask));
                chk(clamp_val == m_val, "R5 request value", 128'(clamp_val), 128'(m_val));
                sc = score_of(clamp_mask, clamp_val);
                dly = $urandom % 4;
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    chk(eval_req && clamp_mask == m_mask, "R3 request held",
                        128'(eval_req), 128'(1));
                end
                eval_score = SW'(sc);
                eval_ack = 1'b1;
                @(negedge clk);
                eval_ack = 1'b0;
                chk(!eval_req, "R3 request drops after ack", 128'(eval_req), 128'(0));
                if (m_phase == 0) begin
                    m_base = sc;
                    m_phase = 1;
                    m_idx = 0;
                    m_changed = 1'b0;
                end else begin
                    if (sc + m_tol < m_base) begin   // R6
                        m_mask[m_idx] = 1'b0;
                        m_val[m_idx]  = 1'b0;
                    end else begin
                        m_changed = 1'b1;
                    end
                    m_idx++;
                end
                model_next();
            end
        end
    end

    task automatic run_case(input int tol, input bit poke_start, output logic [N-1:0] fm,
                            output logic [N-1:0] fv);
        int waited = 0;
        m_phase = 0; m_fin = 1'b0; m_mask = '0; m_val = '0; m_tol = tol; req_count = 0;
        @(negedge clk);
        tolerance = SW'(tol);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        tolerance = '0;
        chk(busy == 1'b1, "R9 busy after start", 128'(busy), 128'(1));
        while (!done && waited < 60000) begin
            if (poke_start && waited == 300) start = 1'b1;
            if (poke_start && waited == 301) start = 1'b0;
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R9 done reached", 128'(done), 128'(1));
        chk(busy == 1'b0, "R9 busy low with done", 128'(busy), 128'(0));
        chk(m_fin == 1'b1, "R8 model also finished", 128'(m_fin), 128'(1));
        chk(clamp_mask == m_mask, "R6 final mask", 128'(clamp_mask), 128'(m_mask));
        chk(clamp_val == m_val, "R10 final value", 128'(clamp_val), 128'(m_val));
        fm = clamp_mask;
        fv = clamp_val;
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", 128'(done), 128'(0));
    endtask

    initial begin
        logic [N-1:0] fm;
        logic [N-1:0] fv;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clamp_mask == '0 && clamp_val == '0, "R1 reset vectors", 128'(clamp_mask), 128'(0));
        chk(!eval_req && !busy && !done, "R1 reset controls",
            128'({eval_req, busy, done}), 128'(0));

        // zero cost: everything kept in one pass, then a confirming pass (R2, R4)
        for (int c = 0; c < N; c++) begin cost0[c] = 0; cost1[c] = 0; end
        run_case(0, 1'b0, fm, fv);
        chk(fm == {N{1'b1}}, "R8 all cells kept", 128'(fm), 128'({N{1'b1}}));
        chk(req_count == N + 1, "R2 one baseline plus one per cell", 128'(req_count),
            128'(N + 1));

        // prohibitive cost: every trial reverted (R6)
        for (int c = 0; c < N; c++) begin cost0[c] = 50; cost1[c] = 50; end
        run_case(3, 1'b0, fm, fv);
        chk(fm == '0 && fv == '0, "R6 all reverted", 128'(fm), 128'(0));

        // only value 1 costly: repeated passes end with all ties at 0 (R5, R8)
        for (int c = 0; c < N; c++) begin cost0[c] = 0; cost1[c] = 7; end
        run_case(0, 1'b1, fm, fv);
        chk(fm == {N{1'b1}} && fv == '0, "R8 retries converge to zero", 128'(fv), 128'(0));

        // cost equal to tolerance: first cell kept at the boundary, then none (R7)
        for (int c = 0; c < N; c++) begin cost0[c] = 2; cost1[c] = 2; end
        run_case(2, 1'b0, fm, fv);
        chk(fm == {{(N-1){1'b0}}, 1'b1}, "R7 equality keeps clamp", 128'(fm), 128'(1));

        // random cost tables at two tolerances
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < N; c++) begin
                cost0[c] = ($urandom % 3 == 0) ? 0 : int'($urandom % 4);
                cost1[c] = ($urandom % 3 == 0) ? 0 : int'($urandom % 4);
            end
            run_case((r == 1) ? 2 : 0, 1'b0, fm, fv);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule